// File: doc/BRIEF.md
# Split-Transaction Bus Ownership Arbiter

This block decides which agent drives a shared split-transaction bus next and when it may begin. The agents are a set of processor or IO modules plus one memory controller, which sits at the highest index. An agent posts a single arbitration request. The request carries a transaction kind, an uncached-write flag and a length in bus cycles. The block stamps the request with the current cycle number, picks a winner, and works out the earliest legal start cycle for that winner. At that cycle it pulses a one-hot grant and then keeps the bus marked busy for the transaction length.

Among the processor and IO modules, the oldest request wins. Ties are broken by a rotating start index. The memory controller overrides them whenever its request is no younger than theirs. The block counts outstanding reads so that it can hold back new read requests when the count reaches a limit. An external hold input keeps write-class traffic off the bus. The start cycle depends on whether the driving agent changes: a change of driver pays a turnaround gap and an arbitration delay, while a repeat driver may follow on with no gap.

Top module: `bus_arb_top`

## Requirements
- R1: After reset, no grant is asserted, the bus is not busy, the owner index is 0, no request is pending, the rotating index is 1 and the outstanding count is 0.
- R2: Each agent holds at most one pending request. A post (post_vld high in cycle t, stamped with t) from an agent that already has one pending raises post_dup in that same cycle and is ignored. The request that was already pending keeps its length and kind.
- R3: Among agents 0..N_PROC-1, the eligible request with the smallest stamp wins. The search starts at the rotating index and wraps. On equal stamps, the first agent met from the rotating index wins. The rotating index advances by one, with wrap, each time such an agent is chosen.
- R4: The memory controller (index N_PROC) wins whenever its pending stamp is less than or equal to the best stamp of the other agents. When it wins, the rotating index does not move. Its requests are never filtered.
- R5: Kind codes are 0 request, 1 reply, 2 coherency, 3 coherency reply, 4 writeback, 5 writepurge and 6 barrier. A kind-0 request with post_uc low is ineligible while the outstanding count equals OUT_LIMIT. The count rises when such a request starts. It falls when a kind 1 or kind 3 transaction starts.
- R6: While wr_hold is high, kinds 3, 4 and 5 are ineligible.
- R7: A decision is made in a cycle c in which the bus frees by c+1. If the winner equals the current owner, its start is the latest of: the previous end, the previous start plus MIN_DLY, and c+1.
- R8: If the owner changes, the start is the latest of: the previous end plus TURN, the stamp plus ARB_DLY, the previous start plus MIN_DLY, and c+1. So an isolated request stamped t starts at t+2.
- R9: The grant is one-hot and lasts one cycle, at the start cycle. owner_id shows the new owner from the next cycle. bus_busy is high for exactly the transaction length, starting with the grant cycle. No start falls before the previous transaction ends.
- R10: When nothing pending is eligible, arbitration is retried on every following cycle. The winner's pending request is cleared at its grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_vld | input | N_PROC+1 | Per-agent request post strobe |
| post_kind | input | (N_PROC+1)x3 | Per-agent transaction kind code |
| post_uc | input | N_PROC+1 | Per-agent uncached-write flag |
| post_len | input | (N_PROC+1)xLEN_W | Per-agent transaction length in cycles (at least 1) |
| wr_hold | input | 1 | Write flow-control hold |
| grant | output | N_PROC+1 | One-cycle one-hot grant at the start cycle |
| owner_id | output | IDX_W | Registered index of the current bus owner |
| bus_busy | output | 1 | Bus driven by the current transaction |
| post_dup | output | N_PROC+1 | Duplicate post flagged and ignored |

## Verification
The bench targets these failure modes:
- Stamp ties: a design that searched from a fixed index, or that moved the rotating index on a memory-controller win, would grant the wrong one of two simultaneous posts.
- Back-to-back starts: a design that applied the turnaround gap to a repeat driver would start one cycle late, and one that skipped it on a driver change would start one cycle early.
- Read limit: a design that ignored the limit, or that throttled uncached writes, would grant while it should block, or block while it should grant.
- Write hold and duplicate posts: a design that let held write-class kinds through would grant them early. A design that let a duplicate post overwrite the pending request would keep the bus busy too long.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

    localparam int unsigned CYC_W = 32;
    localparam int unsigned LEN_W = 8;

    typedef logic [CYC_W-1:0] cyc_t;

    typedef enum logic [2:0] {
        XK_REQ      = 3'd0,
        XK_REPLY    = 3'd1,
        XK_COH      = 3'd2,
        XK_COHREPLY = 3'd3,
        XK_WB       = 3'd4,
        XK_WP       = 3'd5,
        XK_BARRIER  = 3'd6
    } xkind_e;

    typedef struct packed {
        logic             live;
        xkind_e           kind;
        logic             uc;
        logic [LEN_W-1:0] len;
        cyc_t             stamp;
    } slot_t;

    typedef enum logic {
        ST_PICK,
        ST_HOLD
    } arb_st_e;

    // read that occupies an outstanding slot
    function automatic logic is_read_req(xkind_e k, logic uc);
        return (k == XK_REQ) && !uc;
    endfunction

    // transaction that retires an outstanding read
    function automatic logic is_read_ret(xkind_e k);
        return (k == XK_REPLY) || (k == XK_COHREPLY);
    endfunction

    // write-class kinds gated by flow control
    function automatic logic is_wr_class(xkind_e k);
        return (k == XK_COHREPLY) || (k == XK_WB) || (k == XK_WP);
    endfunction

    function automatic cyc_t cmax(cyc_t a, cyc_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bus_arb_slots.sv
module bus_arb_slots
    import bus_arb_pkg::*;
#(
    parameter int unsigned N_SLOT = 5
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [N_SLOT-1:0]           set_vld,
    input  logic [N_SLOT-1:0][2:0]      set_kind,
    input  logic [N_SLOT-1:0]           set_uc,
    input  logic [N_SLOT-1:0][LEN_W-1:0] set_len,
    input  cyc_t                        now,
    input  logic [N_SLOT-1:0]           clr,
    output slot_t [N_SLOT-1:0]          slots,
    output logic [N_SLOT-1:0]           dup
);

    for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
        slot_t r;

        assign dup[g]   = set_vld[g] && r.live && !clr[g];
        assign slots[g] = r;

        always_ff @(posedge clk) begin
            if (rst) begin
                r <= '0;
            end else if (set_vld[g] && !dup[g]) begin
                r.live  <= 1'b1;
                r.kind  <= xkind_e'(set_kind[g]);
                r.uc    <= set_uc[g];
                r.len   <= set_len[g];
                r.stamp <= now;
            end else if (clr[g]) begin
                r.live <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/bus_arb_pick.sv
module bus_arb_pick
    import bus_arb_pkg::*;
#(
    parameter int unsigned N_PROC = 4,
    parameter int unsigned IDX_W  = 3
) (
    input  slot_t [N_PROC:0]  slots,
    input  logic [IDX_W-1:0]  rr,
    input  logic              cnt_full,
    input  logic              hold,
    output logic              pick_vld,
    output logic [IDX_W-1:0]  pick_id,
    output logic              pick_mc
);

    logic             found;
    cyc_t             best;
    logic [IDX_W-1:0] bid;

    always_comb begin
        found = 1'b0;
        best  = '0;
        bid   = '0;
        for (int k = 0; k < int'(N_PROC); k++) begin
            int  j;
            logic ok;
            j = int'(rr) + k;
            if (j >= int'(N_PROC)) j = j - int'(N_PROC);
            ok = slots[j].live
               && !(cnt_full && is_read_req(slots[j].kind, slots[j].uc))
               && !(hold && is_wr_class(slots[j].kind));
            if (ok && (!found || (slots[j].stamp < best))) begin
                found = 1'b1;
                best  = slots[j].stamp;
                bid   = IDX_W'(j);
            end
        end

        pick_mc = slots[N_PROC].live && (!found || (slots[N_PROC].stamp <= best));
        if (pick_mc) begin
            pick_id = IDX_W'(N_PROC);
        end else begin
            pick_id = bid;
        end
        pick_vld = found || pick_mc;
    end

endmodule

// File: rtl/bus_arb_timer.sv
module bus_arb_timer
    import bus_arb_pkg::*;
#(
    parameter int unsigned TURN    = 1,
    parameter int unsigned ARB_DLY = 1,
    parameter int unsigned MIN_DLY = 0
) (
    input  logic same_owner,
    input  cyc_t now,
    input  cyc_t last_start,
    input  cyc_t last_end,
    input  cyc_t stamp,
    output cyc_t start_cyc
);

    cyc_t nxt;
    cyc_t floor_min;
    cyc_t t_same;
    cyc_t t_diff;

    assign nxt       = now + cyc_t'(1);
    assign floor_min = last_start + cyc_t'(MIN_DLY);
    assign t_same    = cmax(cmax(last_end, floor_min), nxt);
    assign t_diff    = cmax(cmax(last_end + cyc_t'(TURN), stamp + cyc_t'(ARB_DLY)),
                            cmax(floor_min, nxt));
    assign start_cyc = same_owner ? t_same : t_diff;

endmodule

// File: rtl/bus_arb_top.sv
module bus_arb_top
    import bus_arb_pkg::*;
#(
    parameter int unsigned N_PROC    = 4,
    parameter int unsigned OUT_LIMIT = 8,
    parameter int unsigned TURN      = 1,
    parameter int unsigned ARB_DLY   = 1,
    parameter int unsigned MIN_DLY   = 0,
    parameter int unsigned IDX_W     = $clog2(N_PROC + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [N_PROC:0]             post_vld,
    input  logic [N_PROC:0][2:0]        post_kind,
    input  logic [N_PROC:0]             post_uc,
    input  logic [N_PROC:0][LEN_W-1:0]  post_len,
    input  logic                        wr_hold,
    output logic [N_PROC:0]             grant,
    output logic [IDX_W-1:0]            owner_id,
    output logic                        bus_busy,
    output logic [N_PROC:0]             post_dup
);

    localparam int unsigned NSLOT = N_PROC + 1;
    localparam int unsigned CNT_W = $clog2(OUT_LIMIT + 1);
    localparam logic [IDX_W-1:0] RR_INIT = IDX_W'((N_PROC > 1) ? 1 : 0);

    cyc_t             now;
    arb_st_e          st;
    logic [IDX_W-1:0] win_id;
    cyc_t             start_at;
    logic [IDX_W-1:0] owner_q;
    logic [IDX_W-1:0] rr_q;
    logic [CNT_W-1:0] cnt_q;
    cyc_t             last_start;
    cyc_t             last_end;

    slot_t [N_PROC:0] slots;
    logic [N_PROC:0]  clr;
    logic             pick_vld;
    logic [IDX_W-1:0] pick_id;
    logic             pick_mc;
    cyc_t             start_calc;
    logic             decide;
    logic             fire;
    slot_t            ws;

    assign fire   = (st == ST_HOLD) && (now == start_at);
    assign clr    = fire ? (NSLOT'(1) << win_id) : '0;
    assign ws     = slots[win_id];
    assign decide = (st == ST_PICK) && ((now + cyc_t'(1)) >= last_end) && pick_vld;

    bus_arb_slots #(.N_SLOT(NSLOT)) u_slots (
        .clk      (clk),
        .rst      (rst),
        .set_vld  (post_vld),
        .set_kind (post_kind),
        .set_uc   (post_uc),
        .set_len  (post_len),
        .now      (now),
        .clr      (clr),
        .slots    (slots),
        .dup      (post_dup)
    );

    bus_arb_pick #(.N_PROC(N_PROC), .IDX_W(IDX_W)) u_pick (
        .slots    (slots),
        .rr       (rr_q),
        .cnt_full (cnt_q >= CNT_W'(OUT_LIMIT)),
        .hold     (wr_hold),
        .pick_vld (pick_vld),
        .pick_id  (pick_id),
        .pick_mc  (pick_mc)
    );

    bus_arb_timer #(.TURN(TURN), .ARB_DLY(ARB_DLY), .MIN_DLY(MIN_DLY)) u_timer (
        .same_owner (pick_id == owner_q),
        .now        (now),
        .last_start (last_start),
        .last_end   (last_end),
        .stamp      (slots[pick_id].stamp),
        .start_cyc  (start_calc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            now        <= '0;
            st         <= ST_PICK;
            win_id     <= '0;
            start_at   <= '0;
            owner_q    <= '0;
            rr_q       <= RR_INIT;
            cnt_q      <= '0;
            last_start <= '0;
            last_end   <= '0;
        end else begin
            now <= now + cyc_t'(1);
            if (decide) begin
                st       <= ST_HOLD;
                win_id   <= pick_id;
                start_at <= start_calc;
                if (!pick_mc) begin
                    rr_q <= (rr_q == IDX_W'(N_PROC - 1)) ? '0 : rr_q + 1'b1;
                end
            end
            if (fire) begin
                st         <= ST_PICK;
                owner_q    <= win_id;
                last_start <= start_at;
                last_end   <= start_at + cyc_t'(ws.len);
                if (is_read_req(ws.kind, ws.uc)) begin
                    if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
                end else if (is_read_ret(ws.kind)) begin
                    if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign grant    = clr;
    assign owner_id = owner_q;
    assign bus_busy = fire || (now < last_end);

endmodule

// File: rtl/bus_arb_chk.sv
module bus_arb_chk
    import bus_arb_pkg::*;
#(
    parameter int unsigned N_PROC    = 4,
    parameter int unsigned OUT_LIMIT = 8,
    parameter int unsigned IDX_W     = 3,
    parameter int unsigned CNT_W     = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [N_PROC:0]  grant,
    input logic [IDX_W-1:0] owner_id,
    input logic             bus_busy,
    input cyc_t             now,
    input cyc_t             last_end,
    input logic [CNT_W-1:0] cnt_q,
    input logic             decide,
    input logic             pick_mc,
    input logic [IDX_W-1:0] rr_q,
    input logic [N_PROC:0]  post_dup,
    input logic [N_PROC:0]  post_vld
);

    localparam int unsigned NSLOT = N_PROC + 1;

    a_r9_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (grant != '0) |=> (grant == '0));

    a_r9_owner_follows: assert property (@(posedge clk) disable iff (rst)
        (grant != '0) |=> ($past(grant) == (NSLOT'(1) << owner_id)));

    a_r9_busy_at_grant: assert property (@(posedge clk) disable iff (rst)
        (grant != '0) |-> bus_busy);

    a_r8_no_overlap: assert property (@(posedge clk) disable iff (rst)
        (grant != '0) |-> (now >= last_end));

    a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(OUT_LIMIT));

    a_r4_mc_keeps_rr: assert property (@(posedge clk) disable iff (rst)
        (decide && pick_mc) |=> $stable(rr_q));

    a_r3_rr_moves: assert property (@(posedge clk) disable iff (rst)
        (decide && !pick_mc && (N_PROC > 1)) |=> (rr_q != $past(rr_q)));

    a_r2_dup_needs_post: assert property (@(posedge clk) disable iff (rst)
        ((post_dup & ~post_vld) == '0));

endmodule

bind bus_arb_top bus_arb_chk #(
    .N_PROC    (N_PROC),
    .OUT_LIMIT (OUT_LIMIT),
    .IDX_W     (IDX_W),
    .CNT_W     (CNT_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .grant    (grant),
    .owner_id (owner_id),
    .bus_busy (bus_busy),
    .now      (now),
    .last_end (last_end),
    .cnt_q    (cnt_q),
    .decide   (decide),
    .pick_mc  (pick_mc),
    .rr_q     (rr_q),
    .post_dup (post_dup),
    .post_vld (post_vld)
);

// File: tb/bus_arb_top_tb_top.sv
module bus_arb_top_tb_top;
    import bus_arb_pkg::*;

    localparam int NP  = 4;
    localparam int NS  = NP + 1;
    localparam int LIM = 2;
    localparam int IW  = 3;

    localparam int K_REQ = 0, K_REPLY = 1, K_COH = 2, K_WB = 4, K_WP = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [NS-1:0]            post_vld  = '0;
    logic [NS-1:0][2:0]       post_kind = '0;
    logic [NS-1:0]            post_uc   = '0;
    logic [NS-1:0][LEN_W-1:0] post_len  = '0;
    logic                     wr_hold   = 1'b0;
    logic [NS-1:0]            grant;
    logic [IW-1:0]            owner_id;
    logic                     bus_busy;
    logic [NS-1:0]            post_dup;

    bus_arb_top #(.N_PROC(NP), .OUT_LIMIT(LIM)) dut_i (
        .clk(clk), .rst(rst), .post_vld(post_vld), .post_kind(post_kind),
        .post_uc(post_uc), .post_len(post_len), .wr_hold(wr_hold),
        .grant(grant), .owner_id(owner_id), .bus_busy(bus_busy), .post_dup(post_dup)
    );

    int cyc;
    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    typedef struct {
        int    mod;
        int    at;
        string tag;
    } exp_t;

    exp_t sbq[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    task automatic check(bit ok, string tag, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic expect_grant(int m, int at, string tag);
        exp_t e;
        e.mod = m;
        e.at  = at;
        e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic put(int m, int k, bit uc, int len);
        post_vld[m]  = 1'b1;
        post_kind[m] = 3'(k);
        post_uc[m]   = uc;
        post_len[m]  = LEN_W'(len);
    endtask

    task automatic drop();
        post_vld = '0;
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops expected grants as the design produces them
    always @(negedge clk) begin
        int   gi;
        exp_t e;
        if (!rst && grant != '0) begin
            gi = -1;
            for (int i = 0; i < NS; i++) if (grant[i]) gi = i;
            if (sbq.size() == 0) begin
                check(1'b0, "R9", "unexpected grant to module", gi, -1);
            end else begin
                e = sbq.pop_front();
                check(gi == e.mod && $onehot(grant), e.tag, "granted module", gi, e.mod);
                check(cyc == e.at, e.tag, "grant cycle", cyc, e.at);
            end
        end
    end

    initial begin
        int c;
        step(3);
        rst = 1'b0;
        step(1);
        // R1 reset state
        check(grant == '0, "R1", "grant after reset", int'(grant), 0);
        check(bus_busy == 1'b0, "R1", "busy after reset", int'(bus_busy), 0);
        check(owner_id == '0, "R1", "owner after reset", int'(owner_id), 0);
        check(post_dup == '0, "R1", "dup after reset", int'(post_dup), 0);
        step(8);

        // R3 tie from rotating index 1, R8 turnaround on driver change
        c = cyc;
        put(1, K_WB, 0, 4);
        put(2, K_WB, 0, 5);
        expect_grant(1, c + 2, "R3 R8");
        expect_grant(2, c + 7, "R8");
        step(1); drop();
        step(4);  // now c+5
        check(bus_busy == 1'b1, "R9", "busy in last cycle of length", int'(bus_busy), 1);
        step(1);  // c+6
        check(bus_busy == 1'b0, "R9", "busy after length", int'(bus_busy), 0);
        step(2);  // c+8: repeat driver posts
        put(2, K_WB, 0, 2);
        expect_grant(2, c + 12, "R7");
        step(1); drop();
        step(12);

        // R4 memory controller beats an equal stamp and keeps the rotating index
        c = cyc;
        put(3, K_WB, 0, 1);
        put(NP, K_REPLY, 0, 2);
        expect_grant(NP, c + 2, "R4");
        expect_grant(3, c + 5, "R4 R8");
        step(1); drop();
        step(7);
        check(owner_id == IW'(3), "R9", "owner index after grant", int'(owner_id), 3);
        step(3);

        // R3 tie again: rotating index must be 1 if R4 held
        c = cyc;
        put(1, K_WB, 0, 1);
        put(2, K_WB, 0, 1);
        expect_grant(1, c + 2, "R3 R4");
        expect_grant(2, c + 4, "R3");
        step(1); drop();
        step(10);

        // R3 oldest wins against the rotating order
        c = cyc;
        put(1, K_WB, 0, 8);
        expect_grant(1, c + 2, "R3");
        step(1); drop();
        step(2);  // c+3
        put(2, K_WB, 0, 1);
        step(1); drop();
        put(0, K_WB, 0, 1);  // c+4
        step(1); drop();
        expect_grant(2, c + 11, "R3");
        expect_grant(0, c + 13, "R3 R8");
        step(16);

        // R5 outstanding limit of 2 reads
        c = cyc;
        put(0, K_REQ, 0, 1);
        expect_grant(0, c + 2, "R5 R7");
        step(1); drop();
        step(2);  // c+3
        put(1, K_REQ, 0, 1);
        expect_grant(1, c + 5, "R5");
        step(1); drop();
        step(2);  // c+6
        put(2, K_REQ, 0, 1);
        put(3, K_REQ, 1, 1);
        expect_grant(3, c + 8, "R5");
        step(1); drop();
        step(8);  // c+15, module 2 still blocked
        check(bus_busy == 1'b0, "R5", "bus idle while read blocked", int'(bus_busy), 0);
        put(NP, K_REPLY, 0, 1);
        expect_grant(NP, c + 17, "R5 R4");
        expect_grant(2, c + 19, "R5 R10");
        step(1); drop();
        step(12);

        // R6 write hold blocks kinds 3,4,5; R10 retry after release
        wr_hold = 1'b1;
        c = cyc;
        put(0, K_WB, 0, 1);
        put(1, K_COH, 0, 1);
        put(3, K_WP, 0, 1);
        expect_grant(1, c + 2, "R6");
        step(1); drop();
        step(7);  // c+8
        wr_hold = 1'b0;
        expect_grant(3, c + 9, "R6 R10");
        expect_grant(0, c + 11, "R6 R10");
        step(12);

        // R2 duplicate post flagged and ignored
        c = cyc;
        put(1, K_WB, 0, 1);
        expect_grant(1, c + 2, "R2");
        step(1); drop();  // c+1
        put(1, K_WB, 0, 6);
        #1;
        check(post_dup[1] == 1'b1, "R2", "duplicate flag", int'(post_dup[1]), 1);
        check(post_dup[0] == 1'b0, "R2", "no flag for idle agent", int'(post_dup[0]), 0);
        step(1); drop();  // c+2
        check(bus_busy == 1'b1, "R2", "busy in grant cycle", int'(bus_busy), 1);
        step(1);          // c+3
        check(bus_busy == 1'b0, "R2", "original length kept", int'(bus_busy), 0);
        step(15);

        check(sbq.size() == 0, "R10", "grants still expected", sbq.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R10 watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule